// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a small microcontroller. Once software turns it on, a clock divider produces one enable every `DIV_RATIO` system clocks. That enable feeds a prescaler of `PRE_BITS` bits, and each prescaler wrap advances a `CNT_BITS`-bit up-counter. When that counter wraps from all ones to zero, the block raises a one-cycle reset request and returns to its idle state.

Software keeps the system alive by reloading the counter before it wraps. A reload is accepted only after software has armed a load-enable flag. Hardware clears that flag on every accepted reload, so each reload needs a fresh arm write. This keeps a runaway program from refreshing the timer by accident. The only way to stop the watchdog is to write one specific key value.

Software drives a single-cycle register write port with three addresses: control, reload and key. The armed and active flags are brought out as read-back outputs. With the defaults, one counter step is 12 × 2048 clocks, and the timeout is (256 − reload value) steps.

Top module: `wdog_top`

## Requirements
- R1: After reset, `active`, `armed` and `resetReq` are all 0. The divider, prescaler and counter start at zero.
- R2: A write to address 0 with data bit 0 set raises `armed` and `active`. If the block was inactive, counting starts from zero, so the timeout comes 2^CNT_BITS steps after that write. A control write with bit 0 clear changes nothing. `armed` is never 1 while `active` is 0.
- R3: A write to address 1 while `armed` is 1 does three things. It loads the counter with the low `CNT_BITS` bits of the data. It clears the divider and the prescaler. It clears `armed`. `resetReq` then rises exactly (2^CNT_BITS − value) × DIV_RATIO × 2^PRE_BITS clock edges after the write edge.
- R4: A write to address 1 while `armed` is 0 is ignored. `armed` stays 0 and the pending timeout keeps its timing.
- R5: A write of 55h (`KEY_VALUE`) to address 2 clears `active` and `armed`. No reset request follows.
- R6: A write of any other value to address 2 has no effect.
- R7: `resetReq` is high for exactly one clock. In that cycle `active` and `armed` already read 0.
- R8: `resetReq` can be raised only if the watchdog was active on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 2 | Register select: 0 control, 1 reload, 2 key |
| wrData | input | 8 | Write data |
| resetReq | output | 1 | One-cycle system reset request on timeout |
| armed | output | 1 | Load-enable flag read-back |
| active | output | 1 | Watchdog running read-back |

## Verification
On every cycle the assertions check the register rules that touch only the write port and the flags. These are: arming, disarming on an accepted reload, the key disable, the ignored reload, and the shape and preconditions of the reset pulse. The exact timeout length depends on the divider, prescaler and counter chained together. The bench shows it by sweeping every reload value of a reduced configuration and counting edges. It also shows, through the timing of the later timeout, that an ignored reload or a wrong key did not touch the counter.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_KEY    = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic run;    // advance divider/prescaler/counter
    logic clear;  // force all timing state to zero
    logic load;   // load counter, zero divider and prescaler
  } dpCmd_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int DIV_RATIO = 12,
  parameter int PRE_BITS  = 11,
  parameter int CNT_BITS  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic [CNT_BITS-1:0] loadVal,
  output logic                overflow
);
  localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

  logic                tick;
  logic                preWrap;
  logic [PRE_BITS-1:0] preCnt;
  logic [CNT_BITS-1:0] stepCnt;

  generate
    if (DIV_RATIO > 1) begin : g_div
      logic [DIV_W-1:0] divCnt;
      assign tick = cmd.run && (divCnt == DIV_W'(DIV_RATIO - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) divCnt <= '0;
        else if (cmd.clear || cmd.load) divCnt <= '0;
        else if (tick) divCnt <= '0;
        else if (cmd.run) divCnt <= divCnt + 1'b1;
      end
    end else begin : g_nodiv
      assign tick = cmd.run;
    end
  endgenerate

  assign preWrap = tick && (&preCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (cmd.clear || cmd.load) preCnt <= '0;
    else if (tick) preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepCnt <= '0;
    else if (cmd.clear) stepCnt <= '0;
    else if (cmd.load) stepCnt <= loadVal;
    else if (preWrap) stepCnt <= stepCnt + 1'b1;
  end

  // control masks this with same-cycle reloads and key writes
  assign overflow = preWrap && (&stepCnt);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_VALUE = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              overflow,
  output dpCmd_t            cmd,
  output logic              resetReq,
  output logic              armed,
  output logic              active
);
  logic keyHit, armWr, reloadOk, timeout;

  assign keyHit   = wrEn && (wrAddr == ADDR_KEY) && (wrData == KEY_VALUE);
  assign armWr    = wrEn && (wrAddr == ADDR_CTRL) && wrData[0];
  assign reloadOk = wrEn && (wrAddr == ADDR_RELOAD) && armed;
  assign timeout  = overflow && !reloadOk && !keyHit;

  always_comb begin
    cmd.run   = active;
    cmd.load  = reloadOk;
    cmd.clear = keyHit || timeout || (armWr && !active);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      armed    <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      if (keyHit) begin
        active <= 1'b0;
        armed  <= 1'b0;
      end else if (reloadOk) begin
        armed  <= 1'b0;
      end else if (timeout) begin
        active   <= 1'b0;
        armed    <= 1'b0;
        resetReq <= 1'b1;
      end else if (armWr) begin
        active <= 1'b1;
        armed  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int DIV_RATIO = 12,
  parameter int PRE_BITS  = 11,
  parameter int CNT_BITS  = 8,
  parameter logic [7:0] KEY_VALUE = 8'h55
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       resetReq,
  output logic       armed,
  output logic       active
);
  dpCmd_t cmd;
  logic   overflow;

  wdog_ctrl #(.KEY_VALUE(KEY_VALUE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .overflow(overflow), .cmd(cmd), .resetReq(resetReq), .armed(armed),
    .active(active)
  );

  wdog_dp #(.DIV_RATIO(DIV_RATIO), .PRE_BITS(PRE_BITS), .CNT_BITS(CNT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadVal(wrData[CNT_BITS-1:0]),
    .overflow(overflow)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter logic [7:0] KEY_VALUE = 8'h55
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic [7:0] wrData,
  input logic       resetReq,
  input logic       armed,
  input logic       active
);
  logic armWr, reloadWr, keyWr;
  assign armWr    = wrEn && wrAddr == 2'd0 && wrData[0];
  assign reloadWr = wrEn && wrAddr == 2'd1;
  assign keyWr    = wrEn && wrAddr == 2'd2 && wrData == KEY_VALUE;

  assert_armed_needs_active_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> active);
  assert_arm_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    armWr |=> (resetReq || (armed && active)));
  assert_reload_disarms_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reloadWr && armed) |=> (!armed && active && !resetReq));
  assert_ignored_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reloadWr && !armed) |=> (!armed && (resetReq || $stable(active))));
  assert_key_disables_R5: assert property (@(posedge clk) disable iff (!rstN)
    keyWr |=> (!active && !armed && !resetReq));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  assert_pulse_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (!active && !armed));
  assert_from_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(active));
endmodule

bind wdog_top wdog_chk #(.KEY_VALUE(KEY_VALUE)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .resetReq(resetReq), .armed(armed), .active(active)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
  localparam int DIV  = 3;
  localparam int PRE  = 2;
  localparam int CNT  = 4;
  localparam int STEP = DIV * (1 << PRE);
  localparam int FULL = 1 << CNT;
  localparam int LIMIT = FULL * STEP + 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic resetReq, armed, active;

  int checks = 0;
  int failures = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  wdog_top #(.DIV_RATIO(DIV), .PRE_BITS(PRE), .CNT_BITS(CNT)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .resetReq(resetReq), .armed(armed), .active(active)
  );

  always @(negedge clk) if (rstN && resetReq) pulses++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!resetReq && n < LIMIT) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  task automatic checkPulse(input string req);
    check(!active && !armed, req, {active, armed}, 0);
    @(posedge clk); @(negedge clk);
    check(!resetReq, req, resetReq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!active, "R1 active", active, 0);
    check(!armed, "R1 armed", armed, 0);
    check(!resetReq, "R1 resetReq", resetReq, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: control write with bit0 clear does nothing
    wr(2'd0, 8'hFE);
    check(!active && !armed, "R2 bit0 clear", {active, armed}, 0);
    // R2: arm from inactive, full-length timeout
    wr(2'd0, 8'h01);
    check(active && armed, "R2 arm", {active, armed}, 3);
    measure(n);
    check(n == FULL * STEP, "R2 timeout from zero", n, FULL * STEP);
    checkPulse("R7 after R2");

    // R3 sweep over every reload value
    for (int v = 0; v < FULL; v++) begin
      wr(2'd0, 8'h01);
      wr(2'd1, 8'(v) | 8'hF0);
      check(active && !armed, "R3 disarm", {active, armed}, 2);
      measure(n);
      check(n == (FULL - v) * STEP, "R3 interval", n, (FULL - v) * STEP);
      checkPulse("R7 sweep");
    end

    // R4: reload without arming is ignored
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd5);
    wr(2'd1, 8'd12);
    check(!armed && active, "R4 flags", {active, armed}, 2);
    measure(n);
    check(n + 1 == (FULL - 5) * STEP, "R4 timing kept", n + 1, (FULL - 5) * STEP);
    checkPulse("R7 after R4");

    // R6: every wrong key in batches of 64
    for (int b = 0; b < 4; b++) begin
      wr(2'd0, 8'h01);
      wr(2'd1, 8'd0);
      p0 = pulses;
      for (int k = b * 64; k < b * 64 + 64; k++) begin
        wr(2'd2, (k == 8'h55) ? 8'h00 : 8'(k));
      end
      check(active && pulses == p0, "R6 wrong keys", active, 1);
      measure(n);
      check(n + 64 == FULL * STEP, "R6 timing kept", n + 64, FULL * STEP);
      checkPulse("R7 after R6");
    end

    // R5: correct key disables, no reset follows
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd14);
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h55);
    check(!active && !armed, "R5 disable", {active, armed}, 0);
    p0 = pulses;
    repeat (FULL * STEP + 10) @(posedge clk);
    @(negedge clk);
    check(pulses == p0, "R5 no reset", pulses - p0, 0);
    // R8: nothing fires while inactive; re-arm still works
    check(!resetReq && !active, "R8 idle", resetReq, 0);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd15);
    measure(n);
    check(n == STEP, "R3 shortest", n, STEP);
    checkPulse("R7 final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule